// File: doc/BRIEF.md
# Four-Phase Non-Overlapping Clock Generator

This block turns one fast oscillator into four clock phases that take turns being high and are never high together. A counter steps once on each leading edge of the oscillator, and a decoder turns its state into exactly one active phase. Every phase output is a positive-going pulse, and each one also has an active-low copy for loads that need that polarity.

Each accepted leading edge also starts a guard window. During the window the decoder output is blanked, so there is a clean gap of a set number of sampling ticks between the fall of one phase and the rise of the next. Timing is modelled in one synchronous domain: a fast sampling clock watches the oscillator level, and the guard window is counted in ticks of that clock. A maintenance gate sits in front of the counter and can freeze the sequence. While the gate is closed, the phase that is currently high stays high.

Top module: `fourPhaseClockGen`

## Requirements
- R1: During reset, and after reset until the first accepted oscillator leading edge, all four phase outputs are low and all four complement outputs are high.
- R2: In every cycle at most one of the phase outputs is high.
- R3: In every cycle each complement output is the exact inverse of its phase output.
- R4: Each accepted leading edge moves the active phase on by one, in the order phase bit 0, bit 1, bit 2, bit 3, then back to bit 0. The first accepted edge after reset selects bit 0.
- R5: Let oscIn first be sampled high at clock edge P0 while it was low at the edge before. The phase that was high stays high until P1. All phases are low from P1 for GUARD_TICKS cycles. The next phase is high from edge P1+GUARD_TICKS onward.
- R6: A leading edge is ignored when gateEn was low at the clock edge where oscIn was first sampled high. An ignored edge leaves the active phase high and unchanged, with no guard gap.
- R7: After the gate is reopened, the next accepted leading edge continues the sequence from the phase that was held.
- R8: A falling edge of oscIn has no effect on any output.
- R9: A synchronous reset applied in the middle of the sequence drives all phases low at the next clock edge. The first accepted edge after release selects phase bit 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock that times all logic and the guard window |
| rst | input | 1 | Synchronous reset, active high |
| oscIn | input | 1 | Base oscillator level; its rising edges step the phases |
| gateEn | input | 1 | Maintenance gate: high passes oscillator edges, low freezes the sequence |
| phase | output | 4 | Active-high phase outputs, one-hot or zero |
| phaseN | output | 4 | Active-low complements of the phase outputs |

## Verification
The interesting overlap is between the maintenance gate and an oscillator leading edge in the same cycle. The bench lowers gateEn on the same negative edge that raises oscIn. It then expects the edge to be dropped whole: no guard gap and no step. The held phase must still be high three samples later. A second overlap is a reset that lands while a phase is high. There the expectation is an immediate drop to all-low with complements all high, and then a restart at phase bit 0 on the next edge.

// File: rtl/fourPhasePkg.sv
package fourPhasePkg;

  // Strobes handed from the edge/guard control to the phase datapath
  typedef struct packed {
    logic advance;   // accepted oscillator leading edge this cycle
    logic blank;     // guard window active: force all phases low
  } phaseStrobes_t;

endpackage

// File: rtl/phaseSeqCtrl.sv
module phaseSeqCtrl #(
  parameter int GUARD_TICKS = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        oscIn,
  input  logic                        gateEn,
  output fourPhasePkg::phaseStrobes_t strobes
);

  localparam int GUARD_W = (GUARD_TICKS < 2) ? 1 : $clog2(GUARD_TICKS + 1);

  logic               oscNow;
  logic               oscPrev;
  logic               gateNow;
  logic [GUARD_W-1:0] guardCnt;
  logic               edgeSeen;

  // Sample the oscillator level and the gate on the same edge
  always_ff @(posedge clk) begin
    if (rst) begin
      oscNow  <= 1'b0;
      oscPrev <= 1'b0;
      gateNow <= 1'b0;
    end else begin
      oscNow  <= oscIn;
      oscPrev <= oscNow;
      gateNow <= gateEn;
    end
  end

  // Leading edge accepted only when the gate was open when it was seen
  assign edgeSeen = oscNow & ~oscPrev & gateNow;

  // Guard window: the advance cycle plus GUARD_TICKS-1 further cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      guardCnt <= '0;
    end else if (edgeSeen) begin
      guardCnt <= GUARD_W'(GUARD_TICKS - 1);
    end else if (guardCnt != '0) begin
      guardCnt <= guardCnt - 1'b1;
    end
  end

  always_comb begin
    strobes.advance = edgeSeen;
    strobes.blank   = edgeSeen | (guardCnt != '0);
  end

endmodule

// File: rtl/phaseDecodeDp.sv
module phaseDecodeDp #(
  parameter int NUM_PHASES = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  fourPhasePkg::phaseStrobes_t strobes,
  output logic [NUM_PHASES-1:0]       phase,
  output logic [NUM_PHASES-1:0]       phaseN
);

  localparam int CNT_W = (NUM_PHASES < 2) ? 1 : $clog2(NUM_PHASES);
  localparam logic [CNT_W-1:0] LAST_STATE = CNT_W'(NUM_PHASES - 1);

  logic [CNT_W-1:0]      stateCnt;
  logic                  armed;
  logic [NUM_PHASES-1:0] decoded;
  logic [NUM_PHASES-1:0] phaseQ;
  logic [NUM_PHASES-1:0] phaseNQ;

  // State counter, parked on the last state so the first step lands on 0
  always_ff @(posedge clk) begin
    if (rst) begin
      stateCnt <= LAST_STATE;
      armed    <= 1'b0;
    end else if (strobes.advance) begin
      stateCnt <= (stateCnt == LAST_STATE) ? '0 : stateCnt + 1'b1;
      armed    <= 1'b1;
    end
  end

  // State decoder: one output per counter state
  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_decode
    assign decoded[i] = armed && (stateCnt == CNT_W'(i));
  end

  // Registered outputs; the true and inverted copies are separate flops
  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ  <= '0;
      phaseNQ <= '1;
    end else if (strobes.blank) begin
      phaseQ  <= '0;
      phaseNQ <= '1;
    end else begin
      phaseQ  <= decoded;
      phaseNQ <= ~decoded;
    end
  end

  assign phase  = phaseQ;
  assign phaseN = phaseNQ;

endmodule

// File: rtl/fourPhaseClockGen.sv
module fourPhaseClockGen #(
  parameter int NUM_PHASES  = 4,
  parameter int GUARD_TICKS = 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  oscIn,
  input  logic                  gateEn,
  output logic [NUM_PHASES-1:0] phase,
  output logic [NUM_PHASES-1:0] phaseN
);

  fourPhasePkg::phaseStrobes_t strobes;

  phaseSeqCtrl #(
    .GUARD_TICKS(GUARD_TICKS)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .oscIn  (oscIn),
    .gateEn (gateEn),
    .strobes(strobes)
  );

  phaseDecodeDp #(
    .NUM_PHASES(NUM_PHASES)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .phase  (phase),
    .phaseN (phaseN)
  );

endmodule

// File: rtl/phaseGenChecker.sv
module phaseGenChecker #(
  parameter int NUM_PHASES  = 4,
  parameter int GUARD_TICKS = 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  oscIn,
  input logic                  gateEn,
  input logic [NUM_PHASES-1:0] phase,
  input logic [NUM_PHASES-1:0] phaseN
);

  logic [NUM_PHASES-1:0] lastHigh;
  logic [7:0]            zeroRun;
  logic [7:0]            gateLowRun;
  logic                  oscSeen;

  always_ff @(posedge clk) begin
    if (rst) begin
      lastHigh   <= '0;
      zeroRun    <= '0;
      gateLowRun <= '0;
      oscSeen    <= 1'b0;
    end else begin
      oscSeen <= oscIn;
      if (phase != '0) begin
        lastHigh <= phase;
        zeroRun  <= '0;
      end else if (zeroRun != 8'hFF) begin
        zeroRun <= zeroRun + 1'b1;
      end
      if (gateEn) gateLowRun <= '0;
      else if (gateLowRun != 8'hFF) gateLowRun <= gateLowRun + 1'b1;
    end
  end

  // R1: reset leaves phases low and complements high
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (phase == '0 && phaseN == '1));

  // R2: never two phases together
  a_r2_one_hot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(phase));

  // R3: complement flops track the true flops
  a_r3_complement: assert property (@(posedge clk) disable iff (rst)
    phaseN == ~phase);

  // R4: a newly risen phase follows the last one in rotation
  a_r4_order: assert property (@(posedge clk) disable iff (rst)
    $rose(|phase) |->
      ((lastHigh == '0) ? (phase == NUM_PHASES'(1))
                        : (phase == {lastHigh[NUM_PHASES-2:0], lastHigh[NUM_PHASES-1]})));

  // R5: gap between phases lasts at least the guard window
  a_r5_guard_gap: assert property (@(posedge clk) disable iff (rst)
    ($rose(|phase) && lastHigh != '0) |-> (zeroRun >= 8'(GUARD_TICKS)));

  // R6: with the gate closed long enough, phases freeze
  a_r6_gate_hold: assert property (@(posedge clk) disable iff (rst)
    (gateLowRun >= 8'(GUARD_TICKS + 3)) |=> $stable(phase));

  // R8: a falling oscillator edge never starts a blank on its own
  a_r8_fall_quiet: assert property (@(posedge clk) disable iff (rst)
    ($fell(oscSeen) && phase != '0 && gateLowRun == '0 && zeroRun == '0)
      |=> (phase != '0));

endmodule

bind fourPhaseClockGen phaseGenChecker #(
  .NUM_PHASES (NUM_PHASES),
  .GUARD_TICKS(GUARD_TICKS)
) u_phaseGenChecker (
  .clk   (clk),
  .rst   (rst),
  .oscIn (oscIn),
  .gateEn(gateEn),
  .phase (phase),
  .phaseN(phaseN)
);

// File: tb/test_fourPhaseClockGen.sv
module test_fourPhaseClockGen;

  localparam int GT = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       oscIn = 1'b0;
  logic       gateEn = 1'b1;
  logic [3:0] phase;
  logic [3:0] phaseN;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  logic [3:0] cur = 4'b0000;

  always #4 clk = ~clk;

  fourPhaseClockGen #(.NUM_PHASES(4), .GUARD_TICKS(GT)) i_fourPhaseClockGen (
    .clk(clk), .rst(rst), .oscIn(oscIn), .gateEn(gateEn),
    .phase(phase), .phaseN(phaseN)
  );

  task automatic check(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] nextOf(input logic [3:0] p);
    return (p == 4'b0000) ? 4'b0001 : {p[2:0], p[3]};
  endfunction

  // R2 / R3 checked on every sample outside reset
  always @(negedge clk) begin
    if (!rst && !done) begin
      check($countones(phase) <= 1, "R2 one-hot", phase, 4'b0000);
      check(phaseN == ~phase, "R3 complement", phaseN, ~phase);
    end
  end

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(phase == 4'b0000, "R1 reset phase", phase, 4'b0000);
    check(phaseN == 4'b1111, "R1 reset phaseN", phaseN, 4'b1111);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check(phase == 4'b0000, "R1 idle after release", phase, 4'b0000);
    cur = 4'b0000;
  endtask

  // One accepted edge with full R5 timing, then a falling edge (R8)
  task automatic t_step(input string tag);
    logic [3:0] nxt;
    nxt = nextOf(cur);
    oscIn = 1'b1;
    @(negedge clk);
    check(phase == cur, {tag, " R5 old phase held"}, phase, cur);
    for (int k = 0; k < GT; k++) begin
      @(negedge clk);
      check(phase == 4'b0000, {tag, " R5 guard gap"}, phase, 4'b0000);
    end
    @(negedge clk);
    check(phase == nxt, {tag, " R4 next phase"}, phase, nxt);
    cur = nxt;
    @(negedge clk);
    oscIn = 1'b0;
    repeat (3) @(negedge clk);
    check(phase == cur, {tag, " R8 falling edge no effect"}, phase, cur);
  endtask

  task automatic t_sequence();
    for (int n = 0; n < 6; n++) t_step("R4 seq");
  endtask

  // Edges while gate closed are ignored (R6), including same-cycle close
  task automatic t_gate();
    gateEn = 1'b0;
    oscIn  = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(phase == cur, "R6 same-cycle close held", phase, cur);
    end
    oscIn = 1'b0;
    repeat (3) @(negedge clk);
    for (int n = 0; n < 3; n++) begin
      oscIn = 1'b1;
      repeat (4) begin
        @(negedge clk);
        check(phase == cur, "R6 gated edge ignored", phase, cur);
      end
      oscIn = 1'b0;
      repeat (3) @(negedge clk);
    end
    gateEn = 1'b1;
    repeat (2) @(negedge clk);
    t_step("R7 reopen");
  endtask

  task automatic t_midReset();
    check(phase != 4'b0000, "R9 phase active before reset", phase, cur);
    rst = 1'b1;
    @(negedge clk);
    check(phase == 4'b0000, "R9 reset drops phases", phase, 4'b0000);
    check(phaseN == 4'b1111, "R9 reset raises complements", phaseN, 4'b1111);
    rst = 1'b0;
    cur = 4'b0000;
    repeat (3) @(negedge clk);
    check(phase == 4'b0000, "R9 idle after release", phase, 4'b0000);
    t_step("R9 restart");
    check(phase == 4'b0001, "R9 restart at bit 0", phase, 4'b0001);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sequence();
    t_gate();
    t_step("R4 continue");
    t_midReset();
    t_step("R4 after restart");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule